// File: doc/BRIEF.md
# PS/2 Device-Side Command Receiver

This block sits on the peripheral end of a PS/2 link and takes in one byte sent by the host. While idle it leaves both open-collector lines released and checks the bus on every system clock. The host announces a byte by holding Data low while Clock is high. When the block sees that, it generates the line clock itself: a low phase and a high phase, each `HALF_CYC` system cycles long. It reads the host's bit in the middle of each high phase.

The first eight samples are the data byte, least significant bit first. The ninth is an odd-parity bit and the tenth is the stop bit. If the stop bit is high, the block pulls Data low while Clock is still high and gives an eleventh clock as the acknowledge. It releases Data during that pulse's high phase. It then reports the byte with a one-cycle valid strobe, or with a one-cycle parity-error strobe if the parity does not match. If the stop bit is low, the host has not let go of Data. The block then keeps clocking without acknowledging, and raises a framing-error strobe once it samples Data high. If the host holds Clock low for `INH_CYC` system cycles before the acknowledge, the frame is dropped.

The FSM states are IDLE, BIT_LO, BIT_HI, ACK_LO, ACK_HI, HOLD_LO and HOLD_HI. The transitions are:
- IDLE→BIT_LO on a request to send.
- BIT_LO→BIT_HI at the end of a phase.
- BIT_HI→BIT_LO while samples remain.
- BIT_HI→ACK_LO after a high stop bit.
- BIT_HI→HOLD_LO after a low stop bit.
- ACK_LO→ACK_HI at the end of a phase.
- ACK_HI→IDLE with a strobe.
- HOLD_LO→HOLD_HI at the end of a phase.
- HOLD_HI→HOLD_LO while Data stays low.
- HOLD_HI→IDLE when Data is seen high.
- BIT_LO or BIT_HI→IDLE on an inhibit abort.

Top module: `ps2_cmd_rx`

## Requirements
- R1: After reset both pull enables are 0 and the three strobes are 0.
- R2: Clocking starts only when the synchronised Data is low and Clock is high. With Clock held low by the host, no clock pulse is produced whatever Data does.
- R3: Every low phase the block drives on Clock lasts exactly `HALF_CYC` system cycles.
- R4: The block samples Data mid-way through the high phase of clocks 1 to 10. Clocks 1 to 8 give byte bits 0 to 7 (LSB first), clock 9 gives the parity bit and clock 10 gives the stop bit. The byte appears on `cmd_byte_o`.
- R5: If the stop bit is 1 and the parity is odd over nine bits, `cmd_valid_o` is high for exactly one cycle once the eleventh clock is over. Both lines are released at that point.
- R6: With a stop bit of 1, the block pulls Data low during the high phase of clock 10 and keeps it low through the low phase of clock 11. It releases Data during the high phase of clock 11, so a good frame has exactly 11 clock falls.
- R7: If the stop bit is 1 and the ninth bit makes the parity even, `cmd_parity_err_o` is high for one cycle and `cmd_valid_o` stays low.
- R8: If the stop bit is 0, the block never pulls Data and keeps issuing clock pulses. At the first high-phase sample with Data high it gives a one-cycle `cmd_frame_err_o` and no valid strobe.
- R9: If Clock reads low for `INH_CYC` consecutive cycles during clocks 1 to 10, the block returns to idle. It releases both lines, raises no strobe and accepts the next request normally.
- R10: At most one of the three strobes is high in any cycle, and each frame raises at most one of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ps2_clk_i | input | 1 | Sampled level of the Clock line |
| ps2_dat_i | input | 1 | Sampled level of the Data line |
| ps2_clk_pull_o | output | 1 | 1 pulls the Clock line low |
| ps2_dat_pull_o | output | 1 | 1 pulls the Data line low |
| cmd_byte_o | output | 8 | Last received byte |
| cmd_valid_o | output | 1 | One-cycle strobe: good byte |
| cmd_parity_err_o | output | 1 | One-cycle strobe: parity mismatch |
| cmd_frame_err_o | output | 1 | One-cycle strobe: stop bit low, Data released late |

## Verification
The checker assumes that the host changes Data only while the block holds Clock low. It also assumes that any inhibit lasts longer than one low phase, which holds because `INH_CYC` exceeds `HALF_CYC`. The bench host model keeps to both. It updates Data three system cycles after each Clock fall, and when it aborts it holds Clock low for longer than `INH_CYC`. It drops Data before releasing Clock, so that release does not read as a fresh request. The line levels are formed as wired-AND of the block's and the host's pull enables, so the block reads back its own drive just as on a real bus.

// File: rtl/ps2_cmd_rx_pkg.sv
package ps2_cmd_rx_pkg;

    localparam int DATA_W     = 8;
    localparam int FRAME_BITS = DATA_W + 2;   // data, parity, stop

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BIT_LO,
        ST_BIT_HI,
        ST_ACK_LO,
        ST_ACK_HI,
        ST_HOLD_LO,
        ST_HOLD_HI
    } rx_state_e;

endpackage

// File: rtl/ps2_rx_line_sync.sv
module ps2_rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    logic [STAGES-1:0] sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;   // released lines read high
        else        sh_q <= {sh_q[STAGES-2:0], line_i};
    end

    assign line_o = sh_q[STAGES-1];
endmodule

// File: rtl/ps2_rx_phase_timer.sv
module ps2_rx_phase_timer #(
    parameter int HALF_CYC = 4000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic mid_tick,
    output logic end_tick
);
    localparam int CW = (HALF_CYC > 2) ? $clog2(HALF_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);
    localparam logic [CW-1:0] MID  = CW'(HALF_CYC / 2);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt_q <= '0;
        else if (restart)      cnt_q <= '0;
        else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
    end

    assign mid_tick = (cnt_q == MID);
    assign end_tick = (cnt_q == LAST);
endmodule

// File: rtl/ps2_rx_inhibit_det.sv
module ps2_rx_inhibit_det #(
    parameter int INH_CYC = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_clk,
    output logic inhibit
);
    localparam int CW = $clog2(INH_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(INH_CYC);

    logic [CW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            run_q <= '0;
        else if (line_clk)     run_q <= '0;
        else if (run_q != LIMIT) run_q <= run_q + 1'b1;
    end

    assign inhibit = (run_q == LIMIT);
endmodule

// File: rtl/ps2_cmd_rx.sv
module ps2_cmd_rx
    import ps2_cmd_rx_pkg::*;
#(
    parameter int HALF_CYC    = 4000,
    parameter int INH_CYC     = 10000,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ps2_clk_i,
    input  logic              ps2_dat_i,
    output logic              ps2_clk_pull_o,
    output logic              ps2_dat_pull_o,
    output logic [DATA_W-1:0] cmd_byte_o,
    output logic              cmd_valid_o,
    output logic              cmd_parity_err_o,
    output logic              cmd_frame_err_o
);
    localparam int CNT_W = $clog2(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] ALL_SAMPLED = CNT_W'(FRAME_BITS);
    localparam logic [CNT_W-1:0] STOP_IDX    = CNT_W'(FRAME_BITS - 1);

    rx_state_e st_q, nxt;
    logic clk_s, dat_s;
    logic mid_tick, end_tick, inhibit;
    logic [FRAME_BITS-1:0] shreg_q;
    logic [CNT_W-1:0]      bit_cnt_q;
    logic [DATA_W-1:0]     byte_q;
    logic clk_pull_q, dat_pull_q, valid_q, perr_q, ferr_q;

    ps2_rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync_clk (
        .clk(clk), .rst_n(rst_n), .line_i(ps2_clk_i), .line_o(clk_s));
    ps2_rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync_dat (
        .clk(clk), .rst_n(rst_n), .line_i(ps2_dat_i), .line_o(dat_s));

    ps2_rx_phase_timer #(.HALF_CYC(HALF_CYC)) u_timer (
        .clk(clk), .rst_n(rst_n), .restart(nxt != st_q),
        .mid_tick(mid_tick), .end_tick(end_tick));

    ps2_rx_inhibit_det #(.INH_CYC(INH_CYC)) u_inhibit (
        .clk(clk), .rst_n(rst_n), .line_clk(clk_s), .inhibit(inhibit));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = st_q;
        unique case (st_q)
            ST_IDLE:    if (clk_s && !dat_s) nxt = ST_BIT_LO;
            ST_BIT_LO: begin
                if (inhibit)       nxt = ST_IDLE;
                else if (end_tick) nxt = ST_BIT_HI;
            end
            ST_BIT_HI: begin
                if (inhibit) nxt = ST_IDLE;
                else if (end_tick) begin
                    if (bit_cnt_q != ALL_SAMPLED)   nxt = ST_BIT_LO;
                    else if (shreg_q[FRAME_BITS-1]) nxt = ST_ACK_LO;
                    else                            nxt = ST_HOLD_LO;
                end
            end
            ST_ACK_LO:  if (end_tick) nxt = ST_ACK_HI;
            ST_ACK_HI:  if (end_tick) nxt = ST_IDLE;
            ST_HOLD_LO: if (end_tick) nxt = ST_HOLD_HI;
            ST_HOLD_HI: begin
                if (mid_tick && dat_s) nxt = ST_IDLE;
                else if (end_tick)     nxt = ST_HOLD_LO;
            end
            default:    nxt = ST_IDLE;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_pull_q <= 1'b0;
            dat_pull_q <= 1'b0;
            valid_q    <= 1'b0;
            perr_q     <= 1'b0;
            ferr_q     <= 1'b0;
            shreg_q    <= '0;
            bit_cnt_q  <= '0;
            byte_q     <= '0;
        end else begin
            valid_q    <= 1'b0;
            perr_q     <= 1'b0;
            ferr_q     <= 1'b0;
            clk_pull_q <= (nxt == ST_BIT_LO) || (nxt == ST_ACK_LO) ||
                          (nxt == ST_HOLD_LO);

            if (st_q == ST_IDLE) bit_cnt_q <= '0;

            if (st_q == ST_BIT_HI && mid_tick && bit_cnt_q != ALL_SAMPLED) begin
                shreg_q   <= {dat_s, shreg_q[FRAME_BITS-1:1]};
                bit_cnt_q <= bit_cnt_q + 1'b1;
                // acknowledge drive begins while Clock is still high
                if (bit_cnt_q == STOP_IDX && dat_s) dat_pull_q <= 1'b1;
            end

            if (st_q == ST_ACK_HI && mid_tick) dat_pull_q <= 1'b0;

            if (st_q == ST_ACK_HI && end_tick) begin
                byte_q <= shreg_q[DATA_W-1:0];
                if (^shreg_q[DATA_W:0]) valid_q <= 1'b1;
                else                    perr_q  <= 1'b1;
            end

            if (st_q == ST_HOLD_HI && mid_tick && dat_s) ferr_q <= 1'b1;

            if (nxt == ST_IDLE) dat_pull_q <= 1'b0;
        end
    end

    assign ps2_clk_pull_o   = clk_pull_q;
    assign ps2_dat_pull_o   = dat_pull_q;
    assign cmd_byte_o       = byte_q;
    assign cmd_valid_o      = valid_q;
    assign cmd_parity_err_o = perr_q;
    assign cmd_frame_err_o  = ferr_q;
endmodule

// File: rtl/ps2_cmd_rx_chk.sv
module ps2_cmd_rx_chk #(
    parameter int HALF_CYC = 4000
) (
    input logic clk,
    input logic rst_n,
    input logic ln_clk_pull,
    input logic ln_dat_pull,
    input logic rx_valid,
    input logic rx_perr,
    input logic rx_ferr
);
    localparam int RW = $clog2(HALF_CYC + 1);
    logic [RW-1:0] lowrun_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                lowrun_q <= '0;
        else if (!ln_clk_pull)                     lowrun_q <= '0;
        else if (int'(lowrun_q) < HALF_CYC)        lowrun_q <= lowrun_q + 1'b1;
    end

    AST_LOW_PHASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ln_clk_pull |-> (int'(lowrun_q) < HALF_CYC)); // R3

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rx_valid, rx_perr, rx_ferr})); // R10

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R5

    AST_LINES_FREE_AT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid || rx_perr || rx_ferr) |-> (!ln_clk_pull && !ln_dat_pull)); // R5

    AST_ACK_SET_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ln_dat_pull) |-> !ln_clk_pull); // R6

    AST_ACK_DROP_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ln_dat_pull) |-> !ln_clk_pull); // R6

    AST_FERR_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ferr |-> !$past(ln_dat_pull)); // R8
endmodule

bind ps2_cmd_rx ps2_cmd_rx_chk #(.HALF_CYC(HALF_CYC)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ln_clk_pull(ps2_clk_pull_o),
    .ln_dat_pull(ps2_dat_pull_o),
    .rx_valid   (cmd_valid_o),
    .rx_perr    (cmd_parity_err_o),
    .rx_ferr    (cmd_frame_err_o)
);

// File: tb/ps2_cmd_rx_tb_top.sv
module ps2_cmd_rx_tb_top;
    localparam int HALF = 20;
    localparam int INH  = 70;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_cp = 1'b0, host_dp = 1'b0;
    logic dut_cp, dut_dp;
    logic line_clk, line_dat;
    logic [7:0] cmd_byte;
    logic v_s, pe_s, fe_s;

    assign line_clk = ~(dut_cp | host_cp);
    assign line_dat = ~(dut_dp | host_dp);

    always #5 clk = ~clk;

    ps2_cmd_rx #(.HALF_CYC(HALF), .INH_CYC(INH), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .ps2_clk_i(line_clk), .ps2_dat_i(line_dat),
        .ps2_clk_pull_o(dut_cp), .ps2_dat_pull_o(dut_dp),
        .cmd_byte_o(cmd_byte), .cmd_valid_o(v_s),
        .cmd_parity_err_o(pe_s), .cmd_frame_err_o(fe_s));

    int total = 0, bad = 0;
    int n_valid = 0, n_perr = 0, n_ferr = 0, n_pulses = 0, n_falls = 0, n_datpull = 0;
    int low_run = 0, last_low = 0;
    logic [7:0] last_byte = 8'h00;
    logic prev_lc = 1'b1, prev_cp = 1'b0;

    always @(negedge clk) begin
        if (v_s) begin n_valid++; last_byte = cmd_byte; end
        if (pe_s) n_perr++;
        if (fe_s) n_ferr++;
        if (dut_cp && !prev_cp) n_pulses++;
        if (!line_clk && prev_lc) n_falls++;
        if (dut_dp) n_datpull++;
        if (!line_clk) low_run++;
        else begin
            if (low_run != 0) last_low = low_run;
            low_run = 0;
        end
        prev_lc = line_clk;
        prev_cp = dut_cp;
    end

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    // drive the first n frame bits, one per Clock fall
    task automatic host_bits(logic [9:0] bits, int n);
        for (int i = 0; i < n; i++) begin
            @(negedge line_clk);
            wait_cyc(3);
            host_dp = ~bits[i];
        end
    endtask

    function automatic logic [9:0] frame_of(logic [7:0] d, logic bad_par, logic stop);
        return {stop, (~^d) ^ bad_par, d};
    endfunction

    // R4/R5/R6/R7/R3/R10 table: bit 8 = corrupt parity, bits 7:0 = byte
    localparam logic [8:0] VEC [0:7] = '{
        9'h000, 9'h0FF, 9'h0A5, 9'h05A, 9'h101, 9'h080, 9'h1C3, 9'h07E };

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int v0, p0, f0, fl0, d0, pu0, ack;
        wait_cyc(4);
        // R1 reset state
        chk("R1 clk pull in reset", int'(dut_cp), 0);
        chk("R1 dat pull in reset", int'(dut_dp), 0);
        rst_n = 1'b1;
        wait_cyc(5);
        chk("R1 clk pull after reset", int'(dut_cp), 0);
        chk("R1 dat pull after reset", int'(dut_dp), 0);
        chk("R1 strobes after reset", int'(v_s) + int'(pe_s) + int'(fe_s), 0);

        // R2 idle bus: no clocking
        pu0 = n_pulses;
        wait_cyc(200);
        chk("R2 idle no pulses", n_pulses - pu0, 0);
        // R2 host inhibits, then Data low: still no clocking
        host_cp = 1'b1; wait_cyc(5); host_dp = 1'b1;
        wait_cyc(150);
        chk("R2 inhibited no pulses", n_pulses - pu0, 0);
        host_dp = 1'b0; wait_cyc(5); host_cp = 1'b0;
        wait_cyc(50);
        chk("R2 release no pulses", n_pulses - pu0, 0);

        // table of frames
        for (int k = 0; k < 8; k++) begin
            logic [7:0] d;
            logic bp;
            d = VEC[k][7:0];
            bp = VEC[k][8];
            v0 = n_valid; p0 = n_perr; f0 = n_ferr; fl0 = n_falls;
            host_dp = 1'b1;
            host_bits(frame_of(d, bp, 1'b1), 10);
            @(negedge line_clk);
            wait_cyc(1);
            ack = int'(line_dat);
            wait_cyc(2 * HALF + 5);
            chk("R6 ack low at clock 11", ack, 0);
            chk("R6 eleven clocks", n_falls - fl0, 11);
            chk("R6 data released after ack", int'(line_dat), 1);
            chk("R3 low phase width", last_low, HALF);
            chk("R5 valid strobe count", n_valid - v0, bp ? 0 : 1);
            chk("R7 parity error count", n_perr - p0, bp ? 1 : 0);
            chk("R10 single strobe per frame", (n_valid - v0) + (n_perr - p0) + (n_ferr - f0), 1);
            if (!bp) chk("R4 received byte", int'(last_byte), int'(d));
        end

        // R8 host keeps Data low through the stop bit
        v0 = n_valid; f0 = n_ferr; fl0 = n_falls; d0 = n_datpull;
        host_dp = 1'b1;
        host_bits(frame_of(8'h6B, 1'b0, 1'b0), 10);
        for (int j = 0; j < 3; j++) @(negedge line_clk);
        wait_cyc(3);
        host_dp = 1'b0;
        wait_cyc(3 * HALF);
        chk("R8 clocking continues", int'((n_falls - fl0) >= 13), 1);
        chk("R8 no ack drive", n_datpull - d0, 0);
        chk("R8 frame error strobe", n_ferr - f0, 1);
        chk("R8 no valid strobe", n_valid - v0, 0);
        chk("R8 lines released", int'(dut_cp) + int'(dut_dp), 0);

        // R9 host aborts after three bits
        v0 = n_valid; p0 = n_perr; f0 = n_ferr;
        host_dp = 1'b1;
        host_bits(frame_of(8'h55, 1'b0, 1'b1), 3);
        host_cp = 1'b1;
        wait_cyc(INH + 30);
        host_dp = 1'b0;
        wait_cyc(5);
        pu0 = n_pulses;
        chk("R9 block releases lines", int'(dut_cp) + int'(dut_dp), 0);
        host_cp = 1'b0;
        wait_cyc(4 * HALF);
        chk("R9 no pulses after abort", n_pulses - pu0, 0);
        chk("R9 no strobe on abort", (n_valid - v0) + (n_perr - p0) + (n_ferr - f0), 0);

        // R9 recovery: next frame is received normally
        v0 = n_valid;
        host_dp = 1'b1;
        host_bits(frame_of(8'h3C, 1'b0, 1'b1), 10);
        @(negedge line_clk);
        wait_cyc(2 * HALF + 6);
        chk("R9 recovery valid", n_valid - v0, 1);
        chk("R9 recovery byte", int'(last_byte), 8'h3C);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule